// File: doc/BRIEF.md
# Mirrored On-Chip ROM Read Controller

This block is a 64-kbyte read-only memory slave on a 32-bit internal data path. Two masters reach it: a CPU port and a DMA port. Each port presents a request, a 28-bit byte address and a size code. The block checks whether the address falls in the region the ROM claims, and whether the access width and alignment are legal for that port. It then returns the addressed bytes on the next clock edge.

Inside the claimed region only the low 16 address bits select a location. Every 64-kbyte shadow of the region therefore reads the same image. The region is made of two 16-Mbyte windows, one with address bit 27 clear and one with it set. A 3-bit operating-mode input enables the ROM as a whole. In any other mode the block never claims a cycle, and that space is left to external memory.

The ROM image is computed by a synthesizable arithmetic function of the word index, so no contents file is loaded. If both ports request in the same cycle, the CPU is served and the DMA port is told to retry.

Top module: `mirrored_rom_ctrl`

## Requirements
- R1: A request is claimed (hit_o high in the same cycle) only when mode_i equals 2 and address bits [26:24] are all zero. In every other case hit_o stays low and no response is produced.
- R2: Address bit 27 and bits [23:16] have no effect on the returned data. Every 64-kbyte shadow reads the same contents.
- R3: The 32-bit word at word index w = address[15:2] equals (w * 32'h9E3779B1 + 32'h3C6EF372) modulo 2^32. This includes the last word at byte offset 16'hFFFC.
- R4: A claimed request produces rsp_valid_o high for exactly the following cycle, with no wait states. An unclaimed cycle produces rsp_valid_o low in the following cycle.
- R5: Size code 0 reads a byte, code 1 a halfword and code 2 a word. The CPU port accepts all three.
- R6: Byte lanes are big-endian and keep their lane position on the bus. Byte offset k drives rsp_data_o[31-8k:24-8k]; a halfword at offset 0 drives [31:16] and at offset 2 drives [15:0]. Lanes not read are zero.
- R7: On the DMA port, size code 2 (word) and code 3 are errors. They set rsp_err_o with rsp_data_o zero. Codes 0 and 1 are served normally.
- R8: A halfword at an odd address, a word whose address bits [1:0] are not zero, or size code 3 on the CPU port gives rsp_err_o high and rsp_data_o zero. The request is still claimed.
- R9: When both ports present claimed requests in the same cycle, the CPU is served, dma_stall_o is high in that cycle, and the response carries rsp_port_o = 0. A response served for the DMA port carries rsp_port_o = 1.
- R10: While reset is held and after it is released, with no request, rsp_valid_o, rsp_err_o, rsp_data_o and rsp_port_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Operating mode; value 2 enables the ROM |
| cpu_req_i | input | 1 | CPU read request |
| cpu_addr_i | input | 28 | CPU byte address |
| cpu_size_i | input | 2 | CPU size code: 0 byte, 1 halfword, 2 word |
| dma_req_i | input | 1 | DMA read request |
| dma_addr_i | input | 28 | DMA byte address |
| dma_size_i | input | 2 | DMA size code: 0 byte, 1 halfword |
| hit_o | output | 1 | The ROM claims the current cycle |
| dma_stall_o | output | 1 | DMA request held off by a CPU request this cycle |
| rsp_valid_o | output | 1 | Response present (one cycle after the claim) |
| rsp_err_o | output | 1 | Response is a size or alignment error |
| rsp_port_o | output | 1 | Response owner: 0 CPU, 1 DMA |
| rsp_data_o | output | 32 | Read data, lane-positioned, unused lanes zero |

## Verification
The claim decoder is exercised in two ways. All eight mode values are tried on one address, which separates the enabling mode from the others. All sixteen values of the top address nibble are tried, which shows that bit 27 is ignored while bits [26:24] decide the claim. Shadow sweeps over bits [23:16] read the same offset through many mirrors. An expected word that moved would then point at incomplete folding of the address.

For words at both ends of the array, every size code is tried at every byte offset on both ports. This separates lane placement, zeroing of the unread lanes, the alignment errors and the narrower DMA width set. Simultaneous requests, and DMA-only requests, tell the priority path apart from plain DMA service.

// File: rtl/mrom_pkg.sv
package mrom_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   // Synthesizable image generator: one word per word index.
   function automatic logic [31:0] rom_word(input logic [31:0] idx,
                                            input logic [31:0] mul,
                                            input logic [31:0] add);
      return idx * mul + add;
   endfunction

endpackage

// File: rtl/mrom_port_dec.sv
module mrom_port_dec
   import mrom_pkg::*;
#(
   parameter int ADDR_W     = 28,
   parameter int AREA_LO    = 24,
   parameter int AREA_HI    = 26,
   parameter int MODE_W     = 3,
   parameter int ROM_MODE   = 2,
   parameter bit ALLOW_WORD = 1'b1
) (
   input  logic              req_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  acc_size_e         size_i,
   input  logic [MODE_W-1:0] mode_i,
   output logic              claim_o,
   output logic              err_o
);

   localparam logic [MODE_W-1:0] MODE_ON = ROM_MODE[MODE_W-1:0];

   generate
      if (AREA_HI >= ADDR_W || AREA_LO > AREA_HI) begin : g_bad_area
         $error("mrom_port_dec: area field outside the address");
      end
   endgenerate

   logic in_area;
   logic mode_ok;
   logic bad_align;
   logic bad_width;

   assign in_area = (addr_i[AREA_HI:AREA_LO] == '0);
   assign mode_ok = (mode_i == MODE_ON);
   assign claim_o = req_i && in_area && mode_ok;

   always_comb begin
      unique case (size_i)
         SZ_HALF: bad_align = addr_i[0];
         SZ_WORD: bad_align = |addr_i[1:0];
         default: bad_align = 1'b0;
      endcase
   end

   generate
      if (ALLOW_WORD) begin : g_wide
         assign bad_width = (size_i == SZ_RSVD);
      end else begin : g_narrow
         assign bad_width = (size_i == SZ_WORD) || (size_i == SZ_RSVD);
      end
   endgenerate

   assign err_o = bad_align || bad_width;

endmodule

// File: rtl/mrom_arb.sv
module mrom_arb (
   input  logic cpu_claim_i,
   input  logic dma_claim_i,
   output logic sel_dma_o,
   output logic hit_o,
   output logic dma_stall_o
);

   assign sel_dma_o   = dma_claim_i && !cpu_claim_i;
   assign hit_o       = cpu_claim_i || dma_claim_i;
   assign dma_stall_o = dma_claim_i && cpu_claim_i;

endmodule

// File: rtl/mrom_lane.sv
module mrom_lane
   import mrom_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic [DATA_W-1:0] word_i,
   input  acc_size_e         size_i,
   input  logic [1:0]        off_i,
   output logic [DATA_W-1:0] data_o
);

   localparam int LANES = DATA_W / 8;

   generate
      if (DATA_W != 32) begin : g_bad_w
         $error("mrom_lane: only a 32-bit data path is supported");
      end
   endgenerate

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam logic [1:0] K = k[1:0];
      localparam int LSB = BIG_ENDIAN ? (DATA_W - 8 - 8 * k) : (8 * k);
      logic en;
      always_comb begin
         unique case (size_i)
            SZ_BYTE: en = (off_i == K);
            SZ_HALF: en = (off_i[1] == K[1]);
            SZ_WORD: en = 1'b1;
            default: en = 1'b0;
         endcase
      end
      assign data_o[LSB +: 8] = en ? word_i[LSB +: 8] : 8'h00;
   end

endmodule

// File: rtl/mirrored_rom_ctrl.sv
module mirrored_rom_ctrl
   import mrom_pkg::*;
#(
   parameter int          ADDR_W     = 28,
   parameter int          DATA_W     = 32,
   parameter int          ROM_AW     = 16,
   parameter int          AREA_LO    = 24,
   parameter int          AREA_HI    = 26,
   parameter int          MODE_W     = 3,
   parameter int          ROM_MODE   = 2,
   parameter bit          BIG_ENDIAN = 1'b1,
   parameter logic [31:0] IMG_MUL    = 32'h9E3779B1,
   parameter logic [31:0] IMG_ADD    = 32'h3C6EF372
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_i,
   input  logic              cpu_req_i,
   input  logic [27:0]       cpu_addr_i,
   input  logic [1:0]        cpu_size_i,
   input  logic              dma_req_i,
   input  logic [27:0]       dma_addr_i,
   input  logic [1:0]        dma_size_i,
   output logic              hit_o,
   output logic              dma_stall_o,
   output logic              rsp_valid_o,
   output logic              rsp_err_o,
   output logic              rsp_port_o,
   output logic [31:0]       rsp_data_o
);

   localparam int IDX_W = ROM_AW - 2;
   localparam int PAD_W = 32 - IDX_W;

   generate
      if (ADDR_W != 28 || DATA_W != 32 || MODE_W != 3) begin : g_bad_port
         $error("mirrored_rom_ctrl: port widths are fixed at 28/32/3");
      end
      if (ROM_AW < 3 || ROM_AW > AREA_LO) begin : g_bad_rom
         $error("mirrored_rom_ctrl: ROM size must fit below the area field");
      end
   endgenerate

   logic cpu_claim, cpu_err;
   logic dma_claim, dma_err;
   logic sel_dma;

   mrom_port_dec #(
      .ADDR_W(ADDR_W), .AREA_LO(AREA_LO), .AREA_HI(AREA_HI),
      .MODE_W(MODE_W), .ROM_MODE(ROM_MODE), .ALLOW_WORD(1'b1)
   ) u_dec_cpu (
      .req_i(cpu_req_i), .addr_i(cpu_addr_i), .size_i(acc_size_e'(cpu_size_i)),
      .mode_i(mode_i), .claim_o(cpu_claim), .err_o(cpu_err)
   );

   mrom_port_dec #(
      .ADDR_W(ADDR_W), .AREA_LO(AREA_LO), .AREA_HI(AREA_HI),
      .MODE_W(MODE_W), .ROM_MODE(ROM_MODE), .ALLOW_WORD(1'b0)
   ) u_dec_dma (
      .req_i(dma_req_i), .addr_i(dma_addr_i), .size_i(acc_size_e'(dma_size_i)),
      .mode_i(mode_i), .claim_o(dma_claim), .err_o(dma_err)
   );

   mrom_arb u_arb (
      .cpu_claim_i(cpu_claim), .dma_claim_i(dma_claim),
      .sel_dma_o(sel_dma), .hit_o(hit_o), .dma_stall_o(dma_stall_o)
   );

   // Mirror folding: only the low ROM_AW bits reach the array.
   logic [ADDR_W-1:0] sel_addr;
   acc_size_e         sel_size;
   logic              sel_err;
   logic [IDX_W-1:0]  word_idx;
   logic [31:0]       img_word;
   logic [31:0]       lane_data;

   assign sel_addr = sel_dma ? dma_addr_i : cpu_addr_i;
   assign sel_size = sel_dma ? acc_size_e'(dma_size_i) : acc_size_e'(cpu_size_i);
   assign sel_err  = sel_dma ? dma_err : cpu_err;
   assign word_idx = sel_addr[ROM_AW-1:2];
   assign img_word = rom_word({{PAD_W{1'b0}}, word_idx}, IMG_MUL, IMG_ADD);

   mrom_lane #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_lane (
      .word_i(img_word), .size_i(sel_size), .off_i(sel_addr[1:0]),
      .data_o(lane_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_o <= 1'b0;
         rsp_err_o   <= 1'b0;
         rsp_port_o  <= 1'b0;
         rsp_data_o  <= '0;
      end else begin
         rsp_valid_o <= hit_o;
         rsp_err_o   <= hit_o && sel_err;
         rsp_port_o  <= hit_o && sel_dma;
         rsp_data_o  <= (hit_o && !sel_err) ? lane_data : '0;
      end
   end

endmodule

// File: rtl/mrom_chk.sv
module mrom_chk #(
   parameter int MODE_W   = 3,
   parameter int ROM_MODE = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [MODE_W-1:0] mode_i,
   input logic              cpu_req_i,
   input logic              dma_req_i,
   input logic              hit_o,
   input logic              dma_stall_o,
   input logic              rsp_valid_o,
   input logic              rsp_err_o,
   input logic              rsp_port_o,
   input logic [31:0]       rsp_data_o
);

   localparam logic [MODE_W-1:0] MODE_ON = ROM_MODE[MODE_W-1:0];

   // R1
   hit_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> (mode_i == MODE_ON) && (cpu_req_i || dma_req_i));

   // R4
   one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> rsp_valid_o);

   // R4
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_o |=> !rsp_valid_o);

   // R8
   err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err_o |-> rsp_valid_o && (rsp_data_o == 32'h0));

   // R9
   stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_stall_o |-> cpu_req_i && dma_req_i && hit_o);

   // R9
   stall_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_stall_o |=> rsp_valid_o && !rsp_port_o);

endmodule

bind mirrored_rom_ctrl mrom_chk #(.MODE_W(MODE_W), .ROM_MODE(ROM_MODE)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
   .cpu_req_i(cpu_req_i), .dma_req_i(dma_req_i),
   .hit_o(hit_o), .dma_stall_o(dma_stall_o),
   .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o),
   .rsp_port_o(rsp_port_o), .rsp_data_o(rsp_data_o)
);

// File: tb/mirrored_rom_ctrl_tb.sv
`timescale 1ns/1ps
module mirrored_rom_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode_i = 3'd2;
   logic        cpu_req_i = 1'b0;
   logic [27:0] cpu_addr_i = '0;
   logic [1:0]  cpu_size_i = '0;
   logic        dma_req_i = 1'b0;
   logic [27:0] dma_addr_i = '0;
   logic [1:0]  dma_size_i = '0;
   logic        hit_o, dma_stall_o, rsp_valid_o, rsp_err_o, rsp_port_o;
   logic [31:0] rsp_data_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   mirrored_rom_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
      .cpu_req_i(cpu_req_i), .cpu_addr_i(cpu_addr_i), .cpu_size_i(cpu_size_i),
      .dma_req_i(dma_req_i), .dma_addr_i(dma_addr_i), .dma_size_i(dma_size_i),
      .hit_o(hit_o), .dma_stall_o(dma_stall_o), .rsp_valid_o(rsp_valid_o),
      .rsp_err_o(rsp_err_o), .rsp_port_o(rsp_port_o), .rsp_data_o(rsp_data_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit exp_claim(input logic [2:0] m, input logic [27:0] a);
      return (m == 3'd2) && (a[26:24] == 3'd0);
   endfunction

   function automatic bit exp_err(input bit is_dma, input logic [27:0] a, input logic [1:0] s);
      if (s == 2'd3) return 1'b1;
      if (is_dma && s == 2'd2) return 1'b1;
      if (s == 2'd1 && a[0]) return 1'b1;
      if (s == 2'd2 && a[1:0] != 2'd0) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [31:0] exp_data(input logic [27:0] a, input logic [1:0] s);
      logic [31:0] w;
      int sh;
      w = {18'd0, a[15:2]} * 32'h9E3779B1 + 32'h3C6EF372;
      if (s == 2'd2) return w;
      if (s == 2'd1) begin
         sh = 16 - 8 * int'(a[1:0]);
         return ((w >> sh) & 32'hFFFF) << sh;
      end
      sh = 24 - 8 * int'(a[1:0]);
      return ((w >> sh) & 32'hFF) << sh;
   endfunction

   // One access on one port; checks the claim and the registered response.
   task automatic one(input bit is_dma, input logic [27:0] a, input logic [1:0] s,
                      input string tag);
      bit cl, er;
      @(negedge clk);
      cpu_req_i = !is_dma; cpu_addr_i = a; cpu_size_i = s;
      dma_req_i = is_dma;  dma_addr_i = a; dma_size_i = s;
      cl = exp_claim(mode_i, a);
      er = exp_err(is_dma, a, s);
      #1;
      check({tag, " R1 hit"}, 32'(hit_o), 32'(cl));
      @(posedge clk); #1;
      cpu_req_i = 1'b0; dma_req_i = 1'b0;
      check({tag, " R4 valid"}, 32'(rsp_valid_o), 32'(cl));
      if (cl) begin
         check({tag, " R7 R8 err"}, 32'(rsp_err_o), 32'(er));
         check({tag, " R3 R6 data"}, rsp_data_o, er ? 32'h0 : exp_data(a, s));
         check({tag, " R9 port"}, 32'(rsp_port_o), 32'(is_dma));
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R10 reset state
      repeat (3) @(posedge clk);
      #1;
      check("R10 valid in reset", 32'(rsp_valid_o), 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R10 valid", 32'(rsp_valid_o), 0);
      check("R10 err", 32'(rsp_err_o), 0);
      check("R10 port", 32'(rsp_port_o), 0);
      check("R10 data", rsp_data_o, 0);

      // R1 mode sweep
      for (int m = 0; m < 8; m++) begin
         mode_i = 3'(m);
         one(1'b0, 28'h0000100, 2'd2, "R1 mode");
      end
      mode_i = 3'd2;

      // R1 R2 area nibble sweep: bit 27 ignored, bits 26:24 decide
      for (int n = 0; n < 16; n++)
         one(1'b0, {4'(n), 24'h000208}, 2'd2, "R1 R2 area");

      // R2 shadows over bits 23:16, both windows
      for (int s = 0; s < 256; s += 17) begin
         one(1'b0, {4'h0, 8'(s), 16'h1234}, 2'd2, "R2 shadow");
         one(1'b1, {4'h8, 8'(s), 16'h5676}, 2'd1, "R2 shadow dma");
      end

      // R3 R5 R6 R7 R8 exhaustive size x offset on chosen words, both ports
      for (int wi = 0; wi < 5; wi++) begin
         logic [13:0] w;
         case (wi)
            0: w = 14'h0000;
            1: w = 14'h0001;
            2: w = 14'h1234;
            3: w = 14'h2AAA;
            default: w = 14'h3FFF;
         endcase
         for (int s = 0; s < 4; s++)
            for (int o = 0; o < 4; o++) begin
               one(1'b0, {12'h000, w, 2'(o)}, 2'(s), "R5 R6 R8 cpu");
               one(1'b1, {12'h800, w, 2'(o)}, 2'(s), "R7 dma");
            end
      end

      // R3 last word in both windows
      one(1'b0, 28'h000FFFC, 2'd2, "R3 last");
      one(1'b0, 28'h8FFFFFC, 2'd2, "R3 last mirror");

      // R9 simultaneous claimed requests
      for (int i = 0; i < 4; i++) begin
         logic [27:0] ca, da;
         ca = 28'h0000040 + 28'(i * 4);
         da = 28'h8010082 + 28'(i * 8);
         @(negedge clk);
         cpu_req_i = 1'b1; cpu_addr_i = ca; cpu_size_i = 2'd2;
         dma_req_i = 1'b1; dma_addr_i = da; dma_size_i = 2'd1;
         #1;
         check("R9 stall", 32'(dma_stall_o), 1);
         check("R9 hit", 32'(hit_o), 1);
         @(posedge clk); #1;
         cpu_req_i = 1'b0; dma_req_i = 1'b0;
         check("R9 port", 32'(rsp_port_o), 0);
         check("R9 data", rsp_data_o, exp_data(ca, 2'd2));
      end

      // R9 CPU unclaimed, DMA claimed: DMA served, no stall
      @(negedge clk);
      cpu_req_i = 1'b1; cpu_addr_i = 28'h1000000; cpu_size_i = 2'd2;
      dma_req_i = 1'b1; dma_addr_i = 28'h0000011; dma_size_i = 2'd0;
      #1;
      check("R9 no stall", 32'(dma_stall_o), 0);
      @(posedge clk); #1;
      cpu_req_i = 1'b0; dma_req_i = 1'b0;
      check("R9 dma port", 32'(rsp_port_o), 1);
      check("R9 dma data", rsp_data_o, exp_data(28'h0000011, 2'd0));

      // R4 idle cycle after traffic
      @(posedge clk); #1;
      check("R4 idle", 32'(rsp_valid_o), 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule